// File: doc/BRIEF.md
# Settling Post-Decimation Filter

This block takes the decimated samples of a first-stage filter and produces the final conversion stream. A two-bit mode input picks one of three paths: samples pass through untouched, they run through a 22-tap low-pass FIR with coefficients set at build time, or they run through that FIR with a fast-settling fallback.

In the fast-settling mode, the block watches for a sudden jump in the input or a channel change. When either occurs, it drops the older history and replaces the FIR output with a running mean of the samples taken since the event. The number of samples in that mean doubles as fresh samples arrive. When the FIR window holds only post-event samples again, the FIR output takes over. The output therefore follows a step within one sample and settles into full filtering after one window length.

Top module: `stage2_filter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0.
- R2: Mode 0 is bypass. A sample accepted with `in_valid` appears unchanged on `out_data` with `out_valid` high in the next cycle.
- R3: Mode 1 is the FIR. Once the 22 newest samples taken since the last clear are available, every accepted sample gives an output one cycle later. The output is sum(c[k]*x[k]), where x[0] is the newest sample and c[k] is `COEF[16k+15:16k]` as a signed value. The sum is rounded by adding 2^14 and then shifted arithmetically right by 15. Before the window is full, no output is produced.
- R4: An FIR result outside the signed 24-bit range is clamped to 8388607 or -8388608.
- R5: In a cycle where `mode` differs from its value in the previous cycle, the sample is dropped and all history, fill and averaging state is cleared. `out_valid` is 0 in the next cycle.
- R6: Mode 3 is reserved. It never raises `out_valid`.
- R7: Mode 2 detects a step. An accepted sample whose absolute difference from the last emitted output is strictly greater than `step_thresh` starts averaging. Detection needs an earlier output since the last clear.
- R8: In mode 2, `chan_switch` high together with `in_valid` starts averaging. In modes 0, 1 and 3 it has no effect.
- R9: After averaging starts, the output is the mean of the newest N samples taken since the start. N is the largest of 1, 2, 4, 8 and 16 that does not exceed that count. The mean is rounded as (sum + N/2) shifted arithmetically right by log2(N).
- R10: When the 22nd sample since the start is accepted, averaging ends and the FIR output of R3 resumes. History from before the start never enters the FIR.
- R11: `out_valid` is high only in the cycle after a cycle with `in_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed first-stage sample |
| mode | input | 2 | 0 bypass, 1 FIR, 2 FIR with fast settling, 3 reserved |
| chan_switch | input | 1 | Channel change marker, sampled with `in_valid` |
| step_thresh | input | 24 | Unsigned step detection threshold |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed filtered sample |

## Verification
The bench keeps the default width, depth and averaging limit. It overrides the coefficient set with one that has negative outer taps and a sum of 2^15. Because the outer taps are negative, a window of full-scale samples with opposite-sign ends pushes the FIR result past the 24-bit range, so the clamping of R4 can be checked in both directions. A constant input still passes through the filter exactly, which lets the bench place a difference of exactly `step_thresh` to check that detection uses a strict comparison.

// File: rtl/stage2_filter.sv
module stage2_filter #(
  parameter int DW = 24,
  parameter int CW = 16,
  parameter int TAPS = 22,
  parameter int AVG_LOG = 4,
  parameter logic [TAPS*CW-1:0] COEF = {
    16'd248, 16'd496, 16'd744, 16'd992, 16'd1240, 16'd1488,
    16'd1736, 16'd1984, 16'd2232, 16'd2480, 16'd2744,
    16'd2744, 16'd2480, 16'd2232, 16'd1984, 16'd1736,
    16'd1488, 16'd1240, 16'd992, 16'd744, 16'd496, 16'd248}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [1:0]           mode,
  input  logic                 chan_switch,
  input  logic [DW-1:0]        step_thresh,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int AW = DW + CW + $clog2(TAPS) + 1;
  localparam int FW = $clog2(TAPS + 1);
  localparam int AVG_N = 1 << AVG_LOG;
  localparam int SW = DW + AVG_LOG + 1;
  localparam int LW = $clog2(AVG_LOG + 1);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CW - 2);
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));

  logic signed [DW-1:0] line [TAPS];
  logic signed [DW-1:0] nl [TAPS];
  logic [FW-1:0] fill, nfill;
  logic avg_on, have_out;
  logic [1:0] mode_q;
  logic signed [DW-1:0] last_out;

  wire chg = mode != mode_q;
  wire fir_path = (mode == 2'd1) || (mode == 2'd2);
  wire signed [DW:0] diff = $signed({in_data[DW-1], in_data}) - $signed({last_out[DW-1], last_out});
  wire [DW:0] mag = diff[DW] ? (DW+1)'(-diff) : diff;
  wire trig = in_valid && !chg && (mode == 2'd2) &&
              (chan_switch || (have_out && (mag > {1'b0, step_thresh})));
  wire use_avg = (trig || avg_on) && (nfill < FW'(TAPS));

  assign nfill = trig ? FW'(1) : ((fill == FW'(TAPS)) ? fill : fill + FW'(1));

  always_comb begin
    nl[0] = in_data;
    for (int k = 1; k < TAPS; k++) nl[k] = line[k-1];
  end

  logic signed [AW-1:0] acc, acc_r;
  logic signed [DW-1:0] fir_out;
  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + AW'($signed(COEF[k*CW +: CW])) * AW'(nl[k]);
    acc_r = (acc + HALF) >>> (CW - 1);
    if (acc_r > MAXV) fir_out = MAXV[DW-1:0];
    else if (acc_r < MINV) fir_out = MINV[DW-1:0];
    else fir_out = acc_r[DW-1:0];
  end

  logic [LW-1:0] lg;
  logic signed [SW-1:0] asum, ahalf, ares;
  always_comb begin
    lg = '0;
    for (int j = 1; j <= AVG_LOG; j++)
      if (nfill >= FW'(1 << j)) lg = LW'(j);
    asum = '0;
    for (int k = 0; k < AVG_N; k++)
      if (k < (1 << lg)) asum = asum + SW'(nl[k]);
    ahalf = SW'((1 << lg) >> 1);
    ares = (asum + ahalf) >>> lg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 2'd0;
      fill      <= '0;
      avg_on    <= 1'b0;
      have_out  <= 1'b0;
      last_out  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < TAPS; k++) line[k] <= '0;
    end else begin
      mode_q    <= mode;
      out_valid <= 1'b0;
      if (chg) begin
        fill     <= '0;
        avg_on   <= 1'b0;
        have_out <= 1'b0;
      end else if (in_valid) begin
        if (mode == 2'd0) begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          last_out  <= in_data;
          have_out  <= 1'b1;
        end else if (fir_path) begin
          for (int k = 0; k < TAPS; k++) line[k] <= nl[k];
          fill   <= nfill;
          avg_on <= use_avg;
          if (use_avg) begin
            out_valid <= 1'b1;
            out_data  <= ares[DW-1:0];
            last_out  <= ares[DW-1:0];
            have_out  <= 1'b1;
          end else if (nfill == FW'(TAPS)) begin
            out_valid <= 1'b1;
            out_data  <= fir_out;
            last_out  <= fir_out;
            have_out  <= 1'b1;
          end
        end
      end
    end
  end

  p_bypass_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && mode_q == 2'd0 && in_valid) |=> (out_valid && out_data == $past(in_data)));
  p_mode_change_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> !out_valid);
  p_reserved_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> !out_valid);
  p_switch_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && mode_q == 2'd2 && in_valid && chan_switch) |=> (out_valid && out_data == $past(in_data)));
  p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(TAPS));
  p_valid_needs_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/test_stage2_filter.sv
module test_stage2_filter;
  localparam int DW = 24;
  localparam int CW = 16;
  localparam int TAPS = 22;
  localparam int AL = 4;
  localparam logic [TAPS*CW-1:0] BC = {16'hFE00, {9{16'd1560}}, {2{16'd2856}}, {9{16'd1560}}, 16'hFE00};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, chan_switch = 1'b0;
  logic [1:0] mode = 2'd0;
  logic signed [DW-1:0] in_data = '0;
  logic [DW-1:0] step_thresh = '0;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  stage2_filter #(.DW(DW), .CW(CW), .TAPS(TAPS), .AVG_LOG(AL), .COEF(BC)) i_stage2_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .mode(mode),
    .chan_switch(chan_switch), .step_thresh(step_thresh), .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int mq = 0, avg = 0, have = 0;
  longint last = 0;
  longint hist[$];
  int cf[TAPS];

  function automatic longint rnd24();
    logic signed [23:0] r;
    r = 24'($urandom);
    return longint'(r);
  endfunction

  task automatic step(bit v, longint d, int m, bit cs);
    bit ev;
    longint ed;
    string tag;
    @(negedge clk);
    in_valid = v; in_data = d[DW-1:0]; mode = m[1:0]; chan_switch = cs;
    ev = 0; ed = 0; tag = "R11";
    if (m != mq) begin
      hist.delete(); avg = 0; have = 0; tag = "R5";
    end else if (v) begin
      if (m == 0) begin
        ev = 1; ed = d; tag = "R2";
      end else if (m == 3) begin
        tag = "R6";
      end else begin
        bit trig;
        longint df;
        trig = 0;
        df = d - last;
        if (df < 0) df = -df;
        if (m == 2 && (cs || (have != 0 && df > longint'(step_thresh)))) trig = 1;
        if (trig) begin hist.delete(); avg = 1; end
        hist.push_front(d);
        if (hist.size() > TAPS) void'(hist.pop_back());
        if (avg != 0 && hist.size() < TAPS) begin
          int n, lg;
          longint s;
          n = 1; lg = 0; s = 0;
          while (n * 2 <= hist.size() && lg < AL) begin n = n * 2; lg++; end
          for (int k = 0; k < n; k++) s += hist[k];
          ev = 1; ed = (s + n / 2) >>> lg;
          tag = trig ? (cs ? "R8" : "R7") : "R9";
        end else begin
          avg = 0;
          tag = (m == 1) ? "R3" : "R10";
          if (hist.size() == TAPS) begin
            longint a;
            a = 0;
            for (int k = 0; k < TAPS; k++) a += longint'(cf[k]) * hist[k];
            ed = (a + 16384) >>> 15;
            if (ed > 8388607) begin ed = 8388607; tag = "R4"; end
            if (ed < -8388608) begin ed = -8388608; tag = "R4"; end
            ev = 1;
          end
        end
      end
      if (ev) begin have = 1; last = ed; end
    end
    mq = m;
    @(posedge clk); #1;
    checks++;
    if (out_valid !== ev || (ev && longint'(out_data) != ed)) begin
      errors++;
      $display("FAIL %s: out_valid=%0b out_data=%0d expected valid=%0b data=%0d",
               tag, out_valid, out_data, ev, ed);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint lvl;
    int m;
    for (int k = 0; k < TAPS; k++)
      cf[k] = (k == 0 || k == TAPS - 1) ? -512 : ((k == 10 || k == 11) ? 2856 : 1560);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1: out_valid=%0b expected 0", out_valid); end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1: out_valid=%0b expected 0", out_valid); end

    // R2 bypass with gaps
    for (int i = 0; i < 12; i++) step(i % 3 != 2, rnd24(), 0, 0);
    // R3, R5, R8 ignored in mode 1
    for (int i = 0; i < 60; i++) step(i % 7 != 3, longint'(int'($urandom % 2001) - 1000), 1, i % 9 == 0);
    // R4 clamp both ways
    for (int i = 0; i < 30; i++) step(1, 8388607, 1, 0);
    step(1, -8388608, 1, 0);
    for (int i = 0; i < 20; i++) step(1, 8388607, 1, 0);
    step(1, -8388608, 1, 0);
    for (int i = 0; i < 30; i++) step(1, -8388608, 1, 0);
    step(1, 8388607, 1, 0);
    for (int i = 0; i < 20; i++) step(1, -8388608, 1, 0);
    step(1, 8388607, 1, 0);
    // R6 reserved mode
    for (int i = 0; i < 10; i++) step(1, rnd24(), 3, i == 4);
    // R7, R9, R10 step then settle
    step_thresh = 24'd1000;
    for (int i = 0; i < 30; i++) step(1, 1000 + longint'(int'($urandom % 101) - 50), 2, 0);
    step(1, 500000, 2, 0);
    for (int i = 0; i < 30; i++) step(1, 500000 + longint'(int'($urandom % 401) - 200), 2, 0);
    // R8 channel switch
    step(1, -200000, 2, 1);
    for (int i = 0; i < 25; i++) step(i % 5 != 1, -200000 + longint'(int'($urandom % 401) - 200), 2, 0);
    // R7 strict threshold: constant input settles exactly
    for (int i = 0; i < 25; i++) step(1, 500000, 2, 0);
    step(1, 501000, 2, 0);
    step(1, 503000, 2, 0);
    // mixed random traffic
    lvl = 0; m = 2;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 200 == 0) m = int'($urandom % 4);
      if ($urandom % 60 == 0) lvl = rnd24() / 2;
      if ($urandom % 300 == 0) step_thresh = 24'($urandom % 5000);
      step($urandom % 5 != 0, lvl + longint'(int'($urandom % 401) - 200), m, $urandom % 100 == 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule